// File: doc/BRIEF.md
# Transaction-Holding SPI Master

This block is an SPI master that a local controller drives through a small set of write strobes. A configuration write loads four things: an 8-bit flag word, a transfer length, a clock divider and a chip-select mask. A later data write starts one shift transfer of between 1 and 32 bits. The word captured from the serial input is then available on a read port.

Chip select is not released when a transfer ends unless that transfer was flagged as the end of the transaction. Several transfers can therefore form one transaction under a single chip-select assertion, such as an 8-bit command followed by a 32-bit data phase. The clock idle level, the sampling phase, the bit order and half-duplex operation are all chosen per transfer through the flags. Output enables let the pins be released for a shared bus.

Top module: `spi_txn_master`

## Requirements
- R1: After reset the block is idle with `busy` low, every `spi_cs` line high (inactive, since the chip-select polarity flag resets to 0), `spi_sclk` low, `rd_data` zero and all three output enables high.
- R2: A configuration write (`cfg_we`) is taken only while idle and only when `dat_we` is low in the same cycle. It loads the flags, the length field (number of bits minus 1), the divider and the chip-select mask. Flag bit positions are: 0 offline, 1 end-of-transaction, 2 capture input, 3 chip-select active level, 4 clock idle level, 5 clock phase, 6 LSB first, 7 half duplex.
- R3: A data write while idle starts a transfer. `busy` is high from the next cycle for exactly (length field + 1) × (divider field + 2) cycles.
- R4: Each bit lasts N = divider + 2 clock cycles. For the first floor(N/2) cycles of the bit, `spi_sclk` sits at the level (clock idle level XOR clock phase), and for the rest of the bit it sits at the opposite level. The divider field of 123 therefore gives N = 125.
- R5: With LSB first clear, bits leave from bit 31 of the written word downward, so a short word is left-aligned. With LSB first set, they leave from bit 0 upward. Each `spi_mosi` bit is valid over its whole bit period.
- R6: Idle `spi_sclk` equals the clock idle level. Exactly one sampling transition happens per bit: the mid-bit change away from the first-half level.
- R7: With the capture-input flag set, `spi_miso` is sampled at each sampling transition, and at the end of the transfer `rd_data` holds the received bits right-aligned. The first bit is the MSB of the length-bit result when LSB first is clear, and bit 0 when it is set. With the flag clear, `rd_data` is unchanged. `rd_data` never changes while idle.
- R8: During a transfer, each `spi_cs` line whose mask bit is set sits at the active level and the others sit at the inactive level. After a transfer with end-of-transaction clear the selection stays asserted; after one with the flag set all lines return to inactive.
- R9: With half duplex and capture input both set, `spi_mosi_oe` is low during the transfer. Otherwise it is high unless offline.
- R10: With offline set, `spi_sclk_oe`, `spi_mosi_oe` and `spi_cs_oe` are all low.
- R11: Configuration and data writes while `busy` is high have no effect on the running transfer, the stored configuration or the following transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_flags | input | 8 | Flag word (bit map in R2) |
| cfg_len | input | 5 | Transfer length in bits minus 1 |
| cfg_div | input | 8 | Clock divider minus 2 |
| cfg_cs | input | 3 | Chip-select mask, one bit per slave |
| dat_we | input | 1 | Data write strobe, starts a transfer |
| dat_wdata | input | 32 | Word to shift out |
| rd_data | output | 32 | Right-aligned captured input word |
| busy | output | 1 | Transfer in progress |
| spi_sclk | output | 1 | Serial clock |
| spi_sclk_oe | output | 1 | Serial clock output enable |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Serial data out enable |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select lines |
| spi_cs_oe | output | 1 | Chip-select output enable |

## Verification
The bench aims at the smallest divider (N = 2) and the largest (N = 257), at 1-bit and 32-bit lengths, and at all four clock idle/phase combinations. Getting the half-period wrong would shift the first sampling transition away from cycle floor(N/2), and an off-by-one in the divider would stretch `busy`. A design that dropped chip select between command and data phases, or kept it after an end-flagged transfer, shows up in the chip-select check taken between transfers. Writes made mid-transfer and a configuration write made together with a data write would lengthen or corrupt the transfer or the one that follows if they were not rejected. An LSB-first capture that was not right-aligned would return the result in the top bits of `rd_data`.

// File: rtl/spi_txn_pkg.sv
// Shared types for the transaction-holding SPI master.
// Assumes the flag word is 8 bits wide with the bit map given in the brief.
package spi_txn_pkg;

    // Per-transfer control flags; the last field sits at bit 0.
    typedef struct packed {
        logic half_dup;
        logic lsb_first;
        logic cpha;
        logic cpol;
        logic cs_pol;
        logic input_en;
        logic end_txn;
        logic offline;
    } spi_flags_t;

endpackage

// File: rtl/spi_txn_cfg.sv
// Configuration register bank: holds flags, length, divider and chip-select
// mask. Assumes the caller qualifies the write strobe (idle, no data write).
module spi_txn_cfg #(
    parameter int NCS   = 3,
    parameter int DIV_W = 8,
    parameter int LEN_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  spi_txn_pkg::spi_flags_t flags_in,
    input  logic [LEN_W-1:0]        len_in,
    input  logic [DIV_W-1:0]        div_in,
    input  logic [NCS-1:0]          cs_in,
    output spi_txn_pkg::spi_flags_t flags_q,
    output logic [LEN_W-1:0]        len_q,
    output logic [DIV_W-1:0]        div_q,
    output logic [NCS-1:0]          cs_q
);

    // Load all configuration fields on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            len_q   <= '0;
            div_q   <= '0;
            cs_q    <= '0;
        end else if (wr) begin
            flags_q <= flags_in;
            len_q   <= len_in;
            div_q   <= div_in;
            cs_q    <= cs_in;
        end
    end

endmodule

// File: rtl/spi_txn_timer.sv
// Bit timer: counts N = div + 2 cycles per bit and marks the mid-bit sampling
// point, the end of each bit and the end of the last bit.
// Assumes div and len_m1 stay stable while run is high.
module spi_txn_timer #(
    parameter int DIV_W = 8,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic [LEN_W-1:0] len_m1,
    output logic             first_half,
    output logic             sample,
    output logic             bit_end,
    output logic             last
);

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] n_cyc;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] bit_q;

    // Derive the bit length and the first-half length from the divider.
    always_comb begin
        n_cyc = {1'b0, div} + CNT_W'(2);
        half  = n_cyc >> 1;
    end

    // Decode the timing events from the cycle and bit counters.
    always_comb begin
        first_half = (cnt_q < half);
        sample     = run && (cnt_q == half - CNT_W'(1));
        bit_end    = run && (cnt_q == n_cyc - CNT_W'(1));
        last       = bit_end && (bit_q == len_m1);
    end

    // Advance the cycle counter within a bit and the bit counter per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else if (run) begin
            if (bit_end) begin
                cnt_q <= '0;
                bit_q <= bit_q + LEN_W'(1);
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/spi_txn_shift.sv
// Shift datapath: a transmit register that sends from its top or bottom bit,
// and a capture register whose result is right-aligned into the read register
// at the end of a transfer with capture enabled.
// Assumes lsb_first, capture_en and len_m1 stay stable during a transfer.
module spi_txn_shift #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lsb_first,
    input  logic              capture_en,
    input  logic              sample,
    input  logic              bit_end,
    input  logic              last,
    input  logic              miso,
    input  logic [LEN_W-1:0]  len_m1,
    output logic              mosi,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] rd_q;
    logic [LEN_W-1:0]  align_sh;

    // Pick the outgoing bit and the right-align distance for LSB-first capture.
    always_comb begin
        mosi     = lsb_first ? tx_q[0] : tx_q[DATA_W-1];
        align_sh = LEN_W'(DATA_W - 1) - len_m1;
        rd_data  = rd_q;
    end

    // Load the transmit word at start and step it at every bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (start) begin
            tx_q <= wdata;
        end else if (bit_end && !last) begin
            tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
        end
    end

    // Collect input bits at each sampling point while capture is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (start) begin
            cap_q <= '0;
        end else if (sample && capture_en) begin
            cap_q <= lsb_first ? {miso, cap_q[DATA_W-1:1]}
                               : {cap_q[DATA_W-2:0], miso};
        end
    end

    // Publish the aligned captured word when a capturing transfer ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (last && capture_en) begin
            rd_q <= lsb_first ? (cap_q >> align_sh) : cap_q;
        end
    end

endmodule

// File: rtl/spi_txn_master.sv
// Transaction-holding SPI master top. Accepts configuration and data writes,
// runs one transfer per data write and keeps chip select asserted until a
// transfer flagged end-of-transaction completes.
// Assumes the caller waits for busy to fall before writing; writes while busy
// are dropped.
module spi_txn_master #(
    parameter int NCS    = 3,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_flags,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [NCS-1:0]    cfg_cs,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              spi_sclk,
    output logic              spi_sclk_oe,
    output logic              spi_mosi,
    output logic              spi_mosi_oe,
    input  logic              spi_miso,
    output logic [NCS-1:0]    spi_cs,
    output logic              spi_cs_oe
);

    import spi_txn_pkg::*;

    spi_flags_t       flags_q;
    logic [LEN_W-1:0] cfg_len_q;
    logic [DIV_W-1:0] cfg_div_q;
    logic [NCS-1:0]   cfg_cs_q;
    logic             busy_q;
    logic             hold_q;
    logic [NCS-1:0]   sel_q;
    logic             start;
    logic             cfg_wr;
    logic             first_half;
    logic             sample;
    logic             bit_end;
    logic             last;
    logic             lead_lvl;

    // Qualify the write strobes: data wins over a same-cycle configuration.
    always_comb begin
        start  = dat_we && !busy_q;
        cfg_wr = cfg_we && !busy_q && !dat_we;
    end

    spi_txn_cfg #(.NCS(NCS), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .flags_in (spi_flags_t'(cfg_flags)),
        .len_in   (cfg_len),
        .div_in   (cfg_div),
        .cs_in    (cfg_cs),
        .flags_q  (flags_q),
        .len_q    (cfg_len_q),
        .div_q    (cfg_div_q),
        .cs_q     (cfg_cs_q)
    );

    spi_txn_timer #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (busy_q),
        .div        (cfg_div_q),
        .len_m1     (cfg_len_q),
        .first_half (first_half),
        .sample     (sample),
        .bit_end    (bit_end),
        .last       (last)
    );

    spi_txn_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wdata      (dat_wdata),
        .lsb_first  (flags_q.lsb_first),
        .capture_en (flags_q.input_en),
        .sample     (sample),
        .bit_end    (bit_end),
        .last       (last),
        .miso       (spi_miso),
        .len_m1     (cfg_len_q),
        .mosi       (spi_mosi),
        .rd_data    (rd_data)
    );

    // Track the busy window and the chip-select hold across transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            hold_q <= 1'b0;
            sel_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            hold_q <= 1'b1;
            sel_q  <= cfg_cs_q;
        end else if (last) begin
            busy_q <= 1'b0;
            if (flags_q.end_txn) begin
                hold_q <= 1'b0;
            end
        end
    end

    // Form the serial clock and the output enables.
    always_comb begin
        lead_lvl    = flags_q.cpol ^ flags_q.cpha;
        busy        = busy_q;
        spi_sclk    = busy_q ? (first_half ? lead_lvl : !lead_lvl) : flags_q.cpol;
        spi_sclk_oe = !flags_q.offline;
        spi_cs_oe   = !flags_q.offline;
        spi_mosi_oe = !flags_q.offline &&
                      !(flags_q.half_dup && flags_q.input_en && busy_q);
    end

    // Drive each chip-select line from the held selection and polarity.
    for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
        always_comb begin
            spi_cs[gi] = (hold_q && sel_q[gi]) ? flags_q.cs_pol : !flags_q.cs_pol;
        end
    end

endmodule

// File: rtl/spi_txn_master_chk.sv
// Assertion checker for the transaction-holding SPI master, bound to the top.
// Assumes the configuration registers it observes are stable while busy.
module spi_txn_master_chk #(
    parameter int NCS    = 3,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              dat_we,
    input logic              busy,
    input logic              spi_sclk,
    input logic [NCS-1:0]    spi_cs,
    input logic [DATA_W-1:0] rd_data,
    input logic [LEN_W-1:0]  len_m1,
    input logic [DIV_W-1:0]  div
);

    logic [31:0] busy_cycles;
    logic [31:0] exp_cycles;

    // Count consecutive busy cycles to check the transfer length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cycles <= '0;
        end else if (busy) begin
            busy_cycles <= busy_cycles + 32'd1;
        end else begin
            busy_cycles <= '0;
        end
    end

    // Expected busy window from the stored length and divider fields.
    always_comb begin
        exp_cycles = (32'(len_m1) + 32'd1) * (32'(div) + 32'd2);
    end

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !busy) |=> busy);

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cycles == exp_cycles));

    // R11
    no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(dat_we));

    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_we && !dat_we) |=> $stable(spi_sclk));

    // R8
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_we && !dat_we) |=> $stable(spi_cs));

    // R7
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_data));

endmodule

bind spi_txn_master spi_txn_master_chk #(
    .NCS(NCS), .DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .dat_we   (dat_we),
    .busy     (busy),
    .spi_sclk (spi_sclk),
    .spi_cs   (spi_cs),
    .rd_data  (rd_data),
    .len_m1   (cfg_len_q),
    .div      (cfg_div_q)
);

// File: tb/spi_txn_master_bench.sv
// Self-checking bench: a bench-side slave model decodes the serial waveform
// and compares it with values computed from the requirements.
module spi_txn_master_bench;

    localparam int F_OFF = 0, F_END = 1, F_IN = 2, F_CSP = 3;
    localparam int F_CPOL = 4, F_CPHA = 5, F_LSB = 6, F_HD = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_flags = '0;
    logic [4:0]  cfg_len = '0;
    logic [7:0]  cfg_div = '0;
    logic [2:0]  cfg_cs = '0;
    logic        dat_we = 1'b0;
    logic [31:0] dat_wdata = '0;
    logic        spi_miso = 1'b0;
    logic [31:0] rd_data;
    logic        busy;
    logic        spi_sclk, spi_sclk_oe, spi_mosi, spi_mosi_oe, spi_cs_oe;
    logic [2:0]  spi_cs;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  m_flags = '0;
    int          m_len = 1;
    int          m_div = 0;
    logic [2:0]  m_cs = '0;
    bit          m_hold = 1'b0;
    logic [31:0] m_rd = '0;

    spi_txn_master u_spi_txn_master (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flags(cfg_flags),
        .cfg_len(cfg_len), .cfg_div(cfg_div), .cfg_cs(cfg_cs),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .rd_data(rd_data),
        .busy(busy), .spi_sclk(spi_sclk), .spi_sclk_oe(spi_sclk_oe),
        .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe), .spi_miso(spi_miso),
        .spi_cs(spi_cs), .spi_cs_oe(spi_cs_oe)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] cs_exp(bit act, bit pol, logic [2:0] m);
        return act ? ((m & {3{pol}}) | (~m & {3{~pol}})) : {3{~pol}};
    endfunction

    function automatic logic [31:0] lmask(int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
    endfunction

    function automatic logic sbit(logic [31:0] sw, int i, int len, bit lsb);
        return lsb ? sw[i] : sw[len-1-i];
    endfunction

    task automatic do_cfg(input logic [7:0] fl, input int len, input int dv,
                          input logic [2:0] cs);
        @(negedge clk);
        cfg_we = 1'b1; cfg_flags = fl; cfg_len = 5'(len - 1);
        cfg_div = 8'(dv); cfg_cs = cs;
        @(negedge clk);
        cfg_we = 1'b0;
        m_flags = fl; m_len = len; m_div = dv; m_cs = cs;
    endtask

    // mode 0: plain; 1: writes while busy (R11); 2: config with start (R2)
    task automatic do_xfer(input logic [31:0] wd, input logic [31:0] sw, input int mode);
        int n = m_div + 2;
        int len = m_len;
        bit lsb = m_flags[F_LSB], cpol = m_flags[F_CPOL], cpha = m_flags[F_CPHA];
        bit inp = m_flags[F_IN], hd = m_flags[F_HD], off = m_flags[F_OFF];
        bit pol = m_flags[F_CSP], endf = m_flags[F_END];
        bit lead = cpol ^ cpha;
        bit exp_moe = !off && !(hd && inp);
        logic prev;
        int cyc = 0, edges = 0, first_edge = -1;
        int mosi_bad = 0, cs_bad = 0, oe_bad = 0;
        @(negedge clk);
        prev = spi_sclk;
        dat_we = 1'b1; dat_wdata = wd; spi_miso = sbit(sw, 0, len, lsb);
        if (mode == 2) begin
            cfg_we = 1'b1; cfg_flags = ~m_flags; cfg_len = 5'(len + 3);
            cfg_div = 8'(m_div + 9); cfg_cs = ~m_cs;
        end
        @(negedge clk);
        dat_we = 1'b0; cfg_we = 1'b0;
        chk(busy === 1'b1, "R3", "busy after data write", 32'(busy), 32'd1);
        while (busy === 1'b1 && cyc < 20000) begin
            cyc++;
            if (mode == 1 && cyc == 2) begin
                cfg_we = 1'b1; cfg_flags = ~m_flags; cfg_len = 5'(len + 5);
                cfg_div = 8'(m_div + 11); cfg_cs = ~m_cs;
                dat_we = 1'b1; dat_wdata = ~wd;
            end else if (mode == 1 && cyc == 3) begin
                cfg_we = 1'b0; dat_we = 1'b0;
            end
            if (spi_cs !== cs_exp(1'b1, pol, m_cs)) cs_bad++;
            if (spi_mosi_oe !== exp_moe || spi_sclk_oe !== !off || spi_cs_oe !== !off)
                oe_bad++;
            if (prev == lead && spi_sclk == !lead) begin
                if (first_edge < 0) first_edge = cyc - 1;
                if (exp_moe || off) begin
                    if (edges < 32 && spi_mosi !== (lsb ? wd[edges] : wd[31-edges]))
                        mosi_bad++;
                end
                edges++;
                spi_miso = (edges < len) ? sbit(sw, edges, len, lsb) : 1'b0;
            end
            prev = spi_sclk;
            @(negedge clk);
        end
        chk(cyc == len * n, "R3", "busy cycles", 32'(cyc), 32'(len * n));
        chk(first_edge == n / 2, "R4", "first sampling transition", 32'(first_edge), 32'(n / 2));
        chk(edges == len, "R6", "sampling transitions", 32'(edges), 32'(len));
        chk(mosi_bad == 0, "R5", "mosi bit mismatches", 32'(mosi_bad), 32'd0);
        chk(cs_bad == 0, "R8", "cs mismatches during transfer", 32'(cs_bad), 32'd0);
        chk(oe_bad == 0, "R9 R10", "output enable mismatches", 32'(oe_bad), 32'd0);
        if (inp) m_rd = sw & lmask(len);
        chk(rd_data === m_rd, "R7", "read register", rd_data, m_rd);
        chk(spi_sclk === cpol, "R6", "idle clock level", 32'(spi_sclk), 32'(cpol));
        m_hold = !endf;
        chk(spi_cs === cs_exp(m_hold, pol, m_cs), "R8", "cs after transfer",
            32'(spi_cs), 32'(cs_exp(m_hold, pol, m_cs)));
        if (mode == 1) begin
            int extra = 0;
            repeat (3) begin
                @(negedge clk);
                if (busy !== 1'b0) extra++;
            end
            chk(extra == 0, "R11", "no transfer from write while busy", 32'(extra), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);
        chk(spi_cs === 3'b111, "R1", "cs after reset", 32'(spi_cs), 32'h7);
        chk(spi_sclk === 1'b0, "R1", "sclk after reset", 32'(spi_sclk), 32'd0);
        chk(rd_data === 32'd0, "R1", "rd_data after reset", rd_data, 32'd0);
        chk({spi_sclk_oe, spi_mosi_oe, spi_cs_oe} === 3'b111, "R1", "enables after reset",
            32'({spi_sclk_oe, spi_mosi_oe, spi_cs_oe}), 32'h7);

        // R8 command then data phase under one chip select, divider 123 (R4)
        do_cfg(8'h00, 8, 123, 3'b110);
        do_xfer(32'h13 << 24, 32'h0, 0);
        do_cfg(8'h02, 32, 123, 3'b110);
        do_xfer(32'hDEAD_BEEF, 32'h0, 0);

        // R7 read: command then 32-bit capture
        do_cfg(8'h00, 8, 2, 3'b001);
        do_xfer(32'h81 << 24, 32'h0, 0);
        do_cfg(8'h06, 32, 2, 3'b001);
        do_xfer(32'h0, 32'hA5C3_0F1E, 0);

        // R7 LSB-first short capture is right-aligned
        do_cfg(8'h46, 8, 0, 3'b010);
        do_xfer(32'h0000_00C5, 32'h0000_003B, 0);

        // R4 largest divider, single bit, all clock modes at smallest divider
        do_cfg(8'h02, 1, 255, 3'b100);
        do_xfer(32'h8000_0000, 32'h0, 0);
        for (int m = 0; m < 4; m++) begin
            do_cfg(8'(8'h06 | (m << 4)), 5, 0, 3'b011);
            do_xfer(32'hB800_0000, 32'h0000_0016, 0);
        end

        // R9 half duplex with capture; R10 offline
        do_cfg(8'h86, 12, 1, 3'b001);
        do_xfer(32'hFFFF_FFFF, 32'h0000_0ABC, 0);
        do_cfg(8'h03, 6, 1, 3'b111);
        do_xfer(32'h5400_0000, 32'h0, 0);

        // R11 writes while busy; the following transfer proves config kept
        do_cfg(8'h12, 10, 3, 3'b101);
        do_xfer(32'hC3A0_0000, 32'h0, 1);
        do_xfer(32'h1234_5678, 32'h0, 0);

        // R2 configuration write together with a data write is dropped
        do_cfg(8'h16, 9, 2, 3'b010);
        do_xfer(32'h6A80_0000, 32'h0000_0155, 2);
        do_xfer(32'h0F00_0000, 32'h0000_00AA, 0);

        // Random mix
        for (int k = 0; k < 40; k++) begin
            logic [7:0] fl;
            fl = 8'($urandom);
            if ($urandom % 8 != 0) fl[F_OFF] = 1'b0;
            do_cfg(fl, int'($urandom % 32) + 1, int'($urandom % 6), 3'($urandom));
            do_xfer($urandom, $urandom, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule